// File: doc/BRIEF.md
# Checkpointable Modulo Counter Wrapper

This block wraps a small synchronous state machine, a modulo counter that steps when its advance input is high. A single register holds a saved copy of the counter's state alongside the working state. Two controls decide what happens at each rising clock edge. A save request copies the working value into the held copy. A restore request injects an external value into the machine. Asserting both at once exchanges the two values.

A parameter bitmask, with one bit per state, lists the states that may be captured. A save taken in any other state leaves the held copy alone. An injected value outside that set is still applied, but a flag reports it in the same cycle. The machine output is the counter value. While a restore is being applied, that output is taken from the injected value rather than the working state. The held copy is always visible on its own output.

Top module: `ckpt_counter_wrap`

## Requirements
- R1: After a synchronous active-high reset, the working state and the held copy both equal the initial state (0 by default), so `mach_out` and `ckpt_out` read 0 with no request pending.
- R2: With `save`=0 and `restore`=0, each rising edge moves the working state to (state+1) mod MODULUS when `din`=1 and holds it when `din`=0. The default MODULUS of 4 gives the sequence 0,1,2,3,0. `ckpt_out` does not change.
- R3: With `save`=1, `restore`=0 and a working state whose bit is set in ALLOW_MASK (default 4'b0101, i.e. states 0 and 2), the edge loads the held copy with the working state. The working state advances as in R2.
- R4: With `save`=1, `restore`=0 and a working state whose ALLOW_MASK bit is clear, the held copy is unchanged. The working state advances as in R2.
- R5: With `restore`=1 and `save`=0, the next working state is the R2 step applied to `ckpt_in` and `din`. The held copy is unchanged.
- R6: While a restore is applied, `mach_out` equals `ckpt_in` in the same cycle, with no clock edge in between. Otherwise `mach_out` equals the working state.
- R7: With `save`=1, `restore`=1 and an allowed working state, the edge loads the held copy with the working state. The next working state is the R2 step applied to `ckpt_in`.
- R8: With `save`=1, `restore`=1 and a working state that is not allowed, the restore is not applied. The working state advances as in R2, the held copy is unchanged, and `mach_out` shows the working state.
- R9: `restore_bad` is 1 in exactly those cycles where a restore is applied with a `ckpt_in` whose ALLOW_MASK bit is clear. The value is still loaded.
- R10: `ckpt_out` always holds a state whose ALLOW_MASK bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Advance request for the counter |
| save | input | 1 | Capture the working state into the held copy |
| restore | input | 1 | Inject `ckpt_in` as the working state |
| ckpt_in | input | W | Value to inject on restore |
| mach_out | output | W | Machine output (the effective state) |
| ckpt_out | output | W | Currently held checkpoint |
| restore_bad | output | 1 | An applied restore value is outside the allowed set |

## Verification
Two kinds of fault are checked. A wrong held copy shows directly on `ckpt_out` one edge after the faulty save or swap. A wrong working state shows on `mach_out` at the next edge, because the counter output is its state. A swap that chooses the wrong branch is caught in the same cycle: `mach_out` shows the working value instead of the injected one, or the reverse. It also shows one edge later on `ckpt_out`. Counting in both allowed and disallowed states keeps a mis-decoded allowed set from hiding.

// File: rtl/ckw_pkg.sv
package ckw_pkg;
   typedef enum logic [1:0] {
      CKW_RUN  = 2'd0,
      CKW_SAVE = 2'd1,
      CKW_LOAD = 2'd2,
      CKW_SWAP = 2'd3
   } ckw_op_e;
endpackage

// File: rtl/ckw_step.sv
module ckw_step #(
   parameter int W       = 2,
   parameter int MODULUS = 4
) (
   input  logic [W-1:0] cur,
   input  logic         adv,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   generate
      if (MODULUS == (1 << W)) begin : g_natural
         always_comb nxt = adv ? cur + 1'b1 : cur;
      end else begin : g_compare
         always_comb begin
            if (!adv)              nxt = cur;
            else if (cur == LAST)  nxt = '0;
            else                   nxt = cur + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ckw_member.sv
module ckw_member #(
   parameter int                  W    = 2,
   parameter int                  NS   = 4,
   parameter logic [NS-1:0]       MASK = 4'b0101
) (
   input  logic [W-1:0] val,
   output logic         ok
);
   logic [NS-1:0] hit;

   generate
      for (genvar i = 0; i < NS; i++) begin : g_st
         assign hit[i] = MASK[i] && (val == W'(i));
      end
   endgenerate

   assign ok = |hit;
endmodule

// File: rtl/ckw_ctrl.sv
module ckw_ctrl
   import ckw_pkg::*;
(
   input  logic save,
   input  logic restore,
   input  logic cur_ok,
   output logic use_ext,
   output logic capture
);
   ckw_op_e op;

   always_comb begin
      unique case ({save, restore})
         2'b10:   op = CKW_SAVE;
         2'b01:   op = CKW_LOAD;
         2'b11:   op = cur_ok ? CKW_SWAP : CKW_RUN;
         default: op = CKW_RUN;
      endcase
   end

   always_comb begin
      use_ext = (op == CKW_LOAD) || (op == CKW_SWAP);
      capture = ((op == CKW_SAVE) && cur_ok) || (op == CKW_SWAP);
   end
endmodule

// File: rtl/ckpt_counter_wrap.sv
module ckpt_counter_wrap #(
   parameter int                   W          = 2,
   parameter int                   MODULUS    = 4,
   parameter int                   INIT_STATE = 0,
   parameter logic [(1<<W)-1:0]    ALLOW_MASK = 4'b0101
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         din,
   input  logic         save,
   input  logic         restore,
   input  logic [W-1:0] ckpt_in,
   output logic [W-1:0] mach_out,
   output logic [W-1:0] ckpt_out,
   output logic         restore_bad
);
   localparam int           NS   = 1 << W;
   localparam logic [W-1:0] INIT = W'(INIT_STATE);

   generate
      if (W < 1 || W > 8) begin : g_bad_w
         $error("ckpt_counter_wrap: W out of range");
      end
      if (MODULUS < 2 || MODULUS > NS) begin : g_bad_mod
         $error("ckpt_counter_wrap: MODULUS must fit in W bits");
      end
      if (INIT_STATE < 0 || INIT_STATE >= MODULUS) begin : g_bad_init
         $error("ckpt_counter_wrap: INIT_STATE outside counter range");
      end
      if (!ALLOW_MASK[INIT_STATE]) begin : g_bad_mask
         $error("ckpt_counter_wrap: INIT_STATE must be an allowed checkpoint");
      end
   endgenerate

   logic [W-1:0] cur_q, ck_q, eff, nxt;
   logic         cur_ok, in_ok, use_ext, capture;

   ckw_member #(.W(W), .NS(NS), .MASK(ALLOW_MASK)) u_cur_ok (
      .val (cur_q),
      .ok  (cur_ok)
   );

   ckw_member #(.W(W), .NS(NS), .MASK(ALLOW_MASK)) u_in_ok (
      .val (ckpt_in),
      .ok  (in_ok)
   );

   ckw_ctrl u_ctrl (
      .save    (save),
      .restore (restore),
      .cur_ok  (cur_ok),
      .use_ext (use_ext),
      .capture (capture)
   );

   assign eff = use_ext ? ckpt_in : cur_q;

   ckw_step #(.W(W), .MODULUS(MODULUS)) u_step (
      .cur (eff),
      .adv (din),
      .nxt (nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= INIT;
         ck_q  <= INIT;
      end else begin
         cur_q <= nxt;
         if (capture) ck_q <= cur_q;
      end
   end

   assign mach_out    = eff;
   assign ckpt_out    = ck_q;
   assign restore_bad = use_ext && !in_ok;
endmodule

// File: rtl/ckpt_counter_wrap_chk.sv
module ckpt_counter_wrap_chk #(
   parameter int                W          = 2,
   parameter logic [(1<<W)-1:0] ALLOW_MASK = 4'b0101
) (
   input logic         clk,
   input logic         rst,
   input logic         din,
   input logic         save,
   input logic         restore,
   input logic [W-1:0] ckpt_in,
   input logic [W-1:0] mach_out,
   input logic [W-1:0] ckpt_out,
   input logic         restore_bad,
   input logic [W-1:0] cur_q
);
   p_ckpt_allowed_r10: assert property (@(posedge clk) disable iff (rst)
      ALLOW_MASK[ckpt_out]);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!save && !restore) |=> $stable(ckpt_out));

   p_save_take_r3: assert property (@(posedge clk) disable iff (rst)
      (save && !restore && ALLOW_MASK[cur_q]) |=> (ckpt_out == $past(cur_q)));

   p_save_skip_r4: assert property (@(posedge clk) disable iff (rst)
      (save && !ALLOW_MASK[cur_q]) |=> $stable(ckpt_out));

   p_restore_next_r5: assert property (@(posedge clk) disable iff (rst)
      (restore && !save && !din) |=> (cur_q == $past(ckpt_in)));

   p_restore_out_r6: assert property (@(posedge clk) disable iff (rst)
      (restore && !save) |-> (mach_out == ckpt_in));

   p_swap_take_r7: assert property (@(posedge clk) disable iff (rst)
      (save && restore && ALLOW_MASK[cur_q]) |=> (ckpt_out == $past(cur_q)));

   p_swap_skip_out_r8: assert property (@(posedge clk) disable iff (rst)
      (save && restore && !ALLOW_MASK[cur_q]) |-> (mach_out == cur_q));

   p_bad_needs_restore_r9: assert property (@(posedge clk) disable iff (rst)
      restore_bad |-> (restore && !ALLOW_MASK[ckpt_in]));

   wire unused_ok = din;
endmodule

bind ckpt_counter_wrap ckpt_counter_wrap_chk #(.W(W), .ALLOW_MASK(ALLOW_MASK)) u_chk (.*);

// File: tb/tb_ckpt_counter_wrap.sv
module tb_ckpt_counter_wrap;
   localparam int         CLK_PERIOD = 10;
   localparam logic [3:0] MASK = 4'b0101;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       din = 1'b0, save = 1'b0, restore = 1'b0;
   logic [1:0] ckpt_in = '0;
   logic [1:0] mach_out, ckpt_out;
   logic       restore_bad;

   int n_chk = 0, n_bad = 0;
   int m_cur = 0, m_ck = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ckpt_counter_wrap dut (
      .clk(clk), .rst(rst), .din(din), .save(save), .restore(restore),
      .ckpt_in(ckpt_in), .mach_out(mach_out), .ckpt_out(ckpt_out),
      .restore_bad(restore_bad)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int stepf(input int s, input bit a);
      return a ? (s + 1) % 4 : s;
   endfunction

   // One clock cycle: drive at negedge, check combinational and held outputs, update model.
   task automatic cyc(input string tag, input bit d, input bit sv, input bit rs, input int ci);
      bit ok_cur, apply, cap;
      int eff;
      @(negedge clk);
      din = d; save = sv; restore = rs; ckpt_in = 2'(ci);
      ok_cur = MASK[m_cur];
      apply  = rs && (!sv || ok_cur);
      cap    = sv && ok_cur;
      eff    = apply ? ci : m_cur;
      #1;
      chk(tag, "mach_out", int'(mach_out), eff);
      chk(tag, "ckpt_out", int'(ckpt_out), m_ck);
      chk(tag, "restore_bad", int'(restore_bad), int'(apply && !MASK[ci]));
      if (cap) m_ck = m_cur;
      m_cur = stepf(eff, d);
   endtask

   task automatic settle(input string tag);
      cyc(tag, 1'b0, 1'b0, 1'b0, 0);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_cur = 0; m_ck = 0;
      #1;
      chk("R1", "mach_out", int'(mach_out), 0);
      chk("R1", "ckpt_out", int'(ckpt_out), 0);
   endtask

   task automatic t_count;
      for (int i = 0; i < 5; i++) cyc("R2", 1'b1, 1'b0, 1'b0, 3);
      cyc("R2", 1'b0, 1'b0, 1'b0, 2);
      cyc("R2", 1'b0, 1'b0, 1'b0, 0);
      settle("R2");
   endtask

   task automatic t_save;
      while (m_cur != 2) cyc("R2", 1'b1, 1'b0, 1'b0, 0);
      cyc("R3", 1'b1, 1'b1, 1'b0, 0);
      settle("R3");
      chk("R3", "ckpt_out", int'(ckpt_out), 2);
      cyc("R4", 1'b0, 1'b1, 1'b0, 0);
      settle("R4");
      chk("R4", "ckpt_out", int'(ckpt_out), 2);
   endtask

   task automatic t_restore;
      cyc("R5", 1'b0, 1'b0, 1'b1, 0);
      settle("R5");
      chk("R5", "mach_out", int'(mach_out), 0);
      cyc("R9", 1'b1, 1'b0, 1'b1, 3);
      settle("R9");
      chk("R9", "mach_out", int'(mach_out), 0);
      cyc("R6", 1'b1, 1'b0, 1'b1, 1);
      settle("R6");
      chk("R6", "mach_out", int'(mach_out), 2);
   endtask

   task automatic t_swap;
      chk("R7", "precond", m_cur, 2);
      cyc("R7", 1'b0, 1'b1, 1'b1, 3);
      settle("R7");
      chk("R7", "mach_out", int'(mach_out), 3);
      chk("R7", "ckpt_out", int'(ckpt_out), 2);
      cyc("R8", 1'b1, 1'b1, 1'b1, 0);
      settle("R8");
      chk("R8", "mach_out", int'(mach_out), 0);
      chk("R8", "ckpt_out", int'(ckpt_out), 2);
      cyc("R10", 1'b0, 1'b1, 1'b1, 1);
      settle("R10");
      chk("R10", "ckpt_out", int'(ckpt_out), 0);
      chk("R10", "mach_out", int'(mach_out), 1);
   endtask

   initial begin
      t_reset();
      t_count();
      t_save();
      t_restore();
      t_swap();
      t_reset();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule